// File: doc/BRIEF.md
# Vertical Three-Line Flicker Filter

This block softens line-to-line flicker when progressive computer graphics are prepared for an interlaced television raster. It accepts a single interleaved 4:2:2 sample stream (chroma and luma bytes alternating, one byte per clock when valid). Each incoming sample is combined with the samples in the same column of the two lines received just before it. The result is a vertically filtered stream at the same rate. Two full lines of history are held inside the block. They are sized by parameter for an active width of up to 800 pixels, and 640-pixel lines fit as well.

The filter is centred on the previous line. The output emitted while line k arrives is therefore the weighted combination of lines k-2 (top), k-1 (middle) and k (bottom). A two-bit select picks one of four weight sets, all expressed in sixteenths. The select is captured only with the first sample of a line, so a whole line is always filtered with one weight set. At the top of a frame, lines that do not exist yet are replaced by the nearest newer line.

Top module: `vflicker_filter`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, `out_valid` is 0.
- R2: `out_valid` equals `in_valid` delayed by exactly two clocks, and each output sample belongs to the input sample accepted two clocks earlier.
- R3: Select code 0 (pass-through) outputs the middle-tap sample, which is the same column of the previous line.
- R4: Select code 1 outputs (4·top + 8·mid + 4·bottom + 8) >> 4, where bottom is the current sample. This rounds half up.
- R5: Select code 2 outputs (5·top + 6·mid + 5·bottom + 8) >> 4.
- R6: Select code 3 outputs (2·top + 12·mid + 2·bottom + 8) >> 4.
- R7: On the line that starts with `in_sof`, the top and middle taps both take the current sample, so the output equals the input sample for every select code.
- R8: On the second line of a frame, the top tap takes the first line's sample in that column, because no older line exists.
- R9: `alg_sel` is sampled only together with a valid sample that has `in_sol` set. Changes on any other cycle do not alter the weights used for the rest of that line.
- R10: The column index restarts at 0 with `in_sol` and advances only on valid samples. Sample n of a line therefore always meets sample n of the earlier lines, so U meets U and V meets V. This holds through idle gaps and for lines shorter than the maximum width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_sol | input | 1 | Marks the first sample of a line (qualified by in_valid) |
| in_sof | input | 1 | Marks the first line of a frame (qualified by in_valid and in_sol) |
| in_data | input | DATA_W | Interleaved 4:2:2 sample, unsigned |
| alg_sel | input | 2 | Weight set select, codes 0 to 3 as in R3 to R6 |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | DATA_W | Filtered sample, unsigned |

## Verification
The bench builds the block with DATA_W=8 and MAX_PIXELS=4, so each history line holds eight samples. With so little storage, every column of every line can be checked against an arithmetic model. The bench sweeps all four select codes over several frames, including ones made only of 0 and 255, and covers the first- and second-line substitution of R7 and R8. The small width also makes it cheap to run lines shorter than the maximum, idle gaps inside a line, and a select that changes partway through a line.

// File: rtl/fvf_pkg.sv
package fvf_pkg;

   // Weight sets are all scaled to sixteenths.
   localparam int WSHIFT = 4;
   localparam int WBITS  = 5;
   localparam int SEL_W  = 2;

   typedef enum logic [SEL_W-1:0] {
      ALG_PASS = 2'd0,
      ALG_121  = 2'd1,
      ALG_565  = 2'd2,
      ALG_161  = 2'd3
   } fvf_alg_t;

   // How many earlier lines of the current frame are available.
   localparam logic [1:0] LVL_FIRST  = 2'd0;
   localparam logic [1:0] LVL_SECOND = 2'd1;
   localparam logic [1:0] LVL_FULL   = 2'd2;

   typedef struct packed {
      logic [WBITS-1:0] w_top;
      logic [WBITS-1:0] w_mid;
      logic [WBITS-1:0] w_bot;
   } fvf_wset_t;

   function automatic fvf_wset_t fvf_weights(input fvf_alg_t alg);
      fvf_wset_t w;
      case (alg)
         ALG_PASS: w = '{w_top: 5'd0, w_mid: 5'd16, w_bot: 5'd0};
         ALG_121:  w = '{w_top: 5'd4, w_mid: 5'd8,  w_bot: 5'd4};
         ALG_565:  w = '{w_top: 5'd5, w_mid: 5'd6,  w_bot: 5'd5};
         default:  w = '{w_top: 5'd2, w_mid: 5'd12, w_bot: 5'd2};
      endcase
      return w;
   endfunction

endpackage

// File: rtl/fvf_ctrl.sv
module fvf_ctrl #(
   parameter int DEPTH = 1600,
   parameter int COL_W = 11
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   input  logic                  in_sol,
   input  logic                  in_sof,
   input  logic [1:0]            alg_sel,
   output logic [COL_W-1:0]      col_now,
   output logic [1:0]            lvl_now,
   output fvf_pkg::fvf_alg_t     alg_now,
   output logic [COL_W-1:0]      col_state,
   output fvf_pkg::fvf_alg_t     alg_state
);
   import fvf_pkg::*;

   localparam logic [COL_W-1:0] COL_LAST = COL_W'(DEPTH - 1);

   logic [COL_W-1:0] col_q;
   logic [1:0]       lvl_q;
   fvf_alg_t         alg_q;
   logic [1:0]       lvl_next_line;

   always_comb begin
      case (lvl_q)
         LVL_FIRST:  lvl_next_line = LVL_SECOND;
         default:    lvl_next_line = LVL_FULL;
      endcase
   end

   always_comb begin
      col_now = in_sol ? '0 : col_q;
      if (in_sol) begin
         lvl_now = in_sof ? LVL_FIRST : lvl_next_line;
         alg_now = fvf_alg_t'(alg_sel);
      end else begin
         lvl_now = lvl_q;
         alg_now = alg_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_q <= '0;
         lvl_q <= LVL_FIRST;
         alg_q <= ALG_PASS;
      end else if (in_valid) begin
         col_q <= (col_now == COL_LAST) ? col_now : col_now + COL_W'(1);
         lvl_q <= lvl_now;
         alg_q <= alg_now;
      end
   end

   assign col_state = col_q;
   assign alg_state = alg_q;

endmodule

// File: rtl/fvf_line_store.sv
module fvf_line_store #(
   parameter int DATA_W   = 8,
   parameter int DEPTH    = 1600,
   parameter int COL_W    = 11,
   parameter int NUM_HIST = 2
) (
   input  logic                              clk,
   input  logic                              we,
   input  logic [COL_W-1:0]                  addr,
   input  logic [DATA_W-1:0]                 wdata,
   output logic [NUM_HIST-1:0][DATA_W-1:0]   rd_q
);

   // chain[h] is the current content of stage h at addr; stage h+1 takes it on write.
   logic [NUM_HIST-1:0][DATA_W-1:0] chain;

   for (genvar h = 0; h < NUM_HIST; h++) begin : g_stage
      logic [DATA_W-1:0] mem [DEPTH];
      logic [DATA_W-1:0] wd;
      logic [DATA_W-1:0] q;

      if (h == 0) begin : g_head
         assign wd = wdata;
      end else begin : g_tail
         assign wd = chain[h-1];
      end

      assign chain[h] = mem[addr];

      always_ff @(posedge clk) begin
         if (we) begin
            mem[addr] <= wd;
            q         <= chain[h];
         end
      end

      assign rd_q[h] = q;
   end

endmodule

// File: rtl/fvf_combine.sv
module fvf_combine #(
   parameter int DATA_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    s_valid,
   input  logic [1:0]              s_lvl,
   input  fvf_pkg::fvf_alg_t       s_alg,
   input  logic [DATA_W-1:0]       s_cur,
   input  logic [DATA_W-1:0]       s_prev1,
   input  logic [DATA_W-1:0]       s_prev2,
   output logic                    out_valid,
   output logic [DATA_W-1:0]       out_data
);
   import fvf_pkg::*;

   localparam int SUM_W = DATA_W + WBITS + 2;
   localparam logic [SUM_W-1:0] HALF = SUM_W'(1 << (WSHIFT - 1));
   localparam logic [SUM_W-1:0] MAXV = SUM_W'((1 << DATA_W) - 1);

   logic [DATA_W-1:0] tap_top, tap_mid, tap_bot;
   fvf_wset_t         w;
   logic [SUM_W-1:0]  sum, rnd;
   logic [DATA_W-1:0] res;

   // Substitute lines that do not exist yet in this frame.
   always_comb begin
      tap_bot = s_cur;
      case (s_lvl)
         LVL_FIRST: begin
            tap_mid = s_cur;
            tap_top = s_cur;
         end
         LVL_SECOND: begin
            tap_mid = s_prev1;
            tap_top = s_prev1;
         end
         default: begin
            tap_mid = s_prev1;
            tap_top = s_prev2;
         end
      endcase
   end

   always_comb begin
      w   = fvf_weights(s_alg);
      sum = SUM_W'(w.w_top) * SUM_W'(tap_top)
          + SUM_W'(w.w_mid) * SUM_W'(tap_mid)
          + SUM_W'(w.w_bot) * SUM_W'(tap_bot);
      rnd = (sum + HALF) >> WSHIFT;
      res = (rnd > MAXV) ? '1 : rnd[DATA_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= s_valid;
         if (s_valid) out_data <= res;
      end
   end

endmodule

// File: rtl/vflicker_filter.sv
module vflicker_filter #(
   parameter int DATA_W            = 8,
   parameter int MAX_PIXELS        = 800,
   parameter int SAMPLES_PER_PIXEL = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_sol,
   input  logic              in_sof,
   input  logic [DATA_W-1:0] in_data,
   input  logic [1:0]        alg_sel,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data
);
   import fvf_pkg::*;

   localparam int DEPTH    = MAX_PIXELS * SAMPLES_PER_PIXEL;
   localparam int COL_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int NUM_HIST = 2;

   if (DATA_W < 1 || DATA_W > 16) begin : g_bad_width
      $error("vflicker_filter: DATA_W must be 1..16");
   end
   if (MAX_PIXELS < 2) begin : g_bad_pixels
      $error("vflicker_filter: MAX_PIXELS must be at least 2");
   end
   if (SAMPLES_PER_PIXEL != 2) begin : g_bad_spp
      $error("vflicker_filter: 4:2:2 interleave needs two samples per pixel");
   end

   logic [COL_W-1:0] col_now, col_state;
   logic [1:0]       lvl_now;
   fvf_alg_t         alg_now, alg_state;

   fvf_ctrl #(.DEPTH(DEPTH), .COL_W(COL_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_sol    (in_sol),
      .in_sof    (in_sof),
      .alg_sel   (alg_sel),
      .col_now   (col_now),
      .lvl_now   (lvl_now),
      .alg_now   (alg_now),
      .col_state (col_state),
      .alg_state (alg_state)
   );

   logic [NUM_HIST-1:0][DATA_W-1:0] hist_q;

   fvf_line_store #(
      .DATA_W(DATA_W), .DEPTH(DEPTH), .COL_W(COL_W), .NUM_HIST(NUM_HIST)
   ) u_store (
      .clk   (clk),
      .we    (in_valid),
      .addr  (col_now),
      .wdata (in_data),
      .rd_q  (hist_q)
   );

   // Stage 1 registers, aligned with the line store read data.
   logic              s1_valid;
   logic [1:0]        s1_lvl;
   fvf_alg_t          s1_alg;
   logic [DATA_W-1:0] s1_cur;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_lvl   <= LVL_FIRST;
         s1_alg   <= ALG_PASS;
         s1_cur   <= '0;
      end else begin
         s1_valid <= in_valid;
         if (in_valid) begin
            s1_lvl <= lvl_now;
            s1_alg <= alg_now;
            s1_cur <= in_data;
         end
      end
   end

   fvf_combine #(.DATA_W(DATA_W)) u_comb (
      .clk       (clk),
      .rst_n     (rst_n),
      .s_valid   (s1_valid),
      .s_lvl     (s1_lvl),
      .s_alg     (s1_alg),
      .s_cur     (s1_cur),
      .s_prev1   (hist_q[0]),
      .s_prev2   (hist_q[1]),
      .out_valid (out_valid),
      .out_data  (out_data)
   );

endmodule

// File: rtl/fvf_checker.sv
module fvf_checker #(
   parameter int DATA_W = 8,
   parameter int COL_W  = 11
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_sol,
   input logic              in_sof,
   input logic [DATA_W-1:0] in_data,
   input logic              out_valid,
   input logic [DATA_W-1:0] out_data,
   input logic [1:0]        alg_state,
   input logic [COL_W-1:0]  col_state
);

   logic [1:0] since_rst;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              since_rst <= 2'd0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   // R1: no output strobe while in reset or on the edge after it.
   assert_reset_quiet_R1: assert property (@(posedge clk) !rst_n |=> !out_valid);

   // R2: strobe follows input strobe two clocks later.
   assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

   // R7: first sample of a frame comes out unchanged.
   assert_frame_head_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 2'd2 && $past(in_valid && in_sol && in_sof, 2))
      |-> (out_valid && out_data == $past(in_data, 2)));

   // R9: captured select holds unless a line starts.
   assert_sel_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_valid && in_sol) |=> $stable(alg_state));

   // R10: column restarts with a line and the next column is 1.
   assert_col_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_sol) |=> (col_state == COL_W'(1)));

endmodule

bind vflicker_filter fvf_checker #(.DATA_W(DATA_W), .COL_W(COL_W)) u_fvf_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_sol    (in_sol),
   .in_sof    (in_sof),
   .in_data   (in_data),
   .out_valid (out_valid),
   .out_data  (out_data),
   .alg_state (alg_state),
   .col_state (col_state)
);

// File: tb/tb_vflicker_filter.sv
module tb_vflicker_filter;
   localparam int W  = 8;
   localparam int MP = 4;
   localparam int NS = MP * 2;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0, in_sol = 1'b0, in_sof = 1'b0;
   logic [W-1:0] in_data = '0;
   logic [1:0]   alg_sel = 2'd0;
   logic         out_valid;
   logic [W-1:0] out_data;

   always #10 clk = ~clk;

   vflicker_filter #(.DATA_W(W), .MAX_PIXELS(MP)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sol(in_sol), .in_sof(in_sof),
      .in_data(in_data), .alg_sel(alg_sel), .out_valid(out_valid), .out_data(out_data)
   );

   int errors = 0;
   int checks = 0;

   // Bench model state
   int m1 [NS];
   int m2 [NS];
   int mcol = 0, mlvl = 0, malg = 0;
   // two-stage expectation pipeline
   bit pv0 = 0, pv1 = 0;
   int pd0 = 0, pd1 = 0;
   string pt0 = "", pt1 = "";

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int filt(input int a, input int t, input int m, input int b);
      int wt, wm, wb, r;
      case (a)
         0: begin wt = 0; wm = 16; wb = 0; end
         1: begin wt = 4; wm = 8;  wb = 4; end
         2: begin wt = 5; wm = 6;  wb = 5; end
         default: begin wt = 2; wm = 12; wb = 2; end
      endcase
      r = (wt * t + wm * m + wb * b + 8) / 16;
      if (r > 255) r = 255;
      return r;
   endfunction

   task automatic put(input bit v, input bit sol, input bit sof, input int d, input int a, input string tag);
      int e, t, m;
      string tg;
      @(negedge clk);
      chk(out_valid == pv1, "R2", int'(out_valid), int'(pv1));
      if (pv1) chk(int'(out_data) == pd1, pt1, int'(out_data), pd1);
      pv1 = pv0; pd1 = pd0; pt1 = pt0;
      e = 0; tg = tag;
      if (v) begin
         if (sol) begin
            mcol = 0;
            mlvl = sof ? 0 : ((mlvl >= 1) ? 2 : 1);
            malg = a;
         end
         if (mlvl == 0) begin m = d; t = d; end
         else if (mlvl == 1) begin m = m1[mcol]; t = m1[mcol]; end
         else begin m = m1[mcol]; t = m2[mcol]; end
         e = filt(malg, t, m, d);
         if (tg == "") begin
            if (mlvl == 0) tg = "R7";
            else if (mlvl == 1) tg = "R8";
            else case (malg)
               0: tg = "R3";
               1: tg = "R4";
               2: tg = "R5";
               default: tg = "R6";
            endcase
         end
         m2[mcol] = m1[mcol];
         m1[mcol] = d;
         if (mcol < NS - 1) mcol++;
      end
      pv0 = v; pd0 = e; pt0 = tg;
      in_valid = v; in_sol = sol; in_sof = sof; in_data = W'(d); alg_sel = 2'(a);
   endtask

   function automatic int pat(input int f, input int l, input int c);
      if (f % 3 == 1) return ((l + c) % 2 == 1) ? 255 : 0;
      return (l * 37 + c * 53 + f * 29 + 7) & 255;
   endfunction

   // One line; alg_mid is driven on samples after the first (R9); gap inserts idle cycles (R10).
   task automatic line(input int f, input int l, input int ns, input int alg, input int alg_mid,
                       input bit gap, input string tag);
      for (int c = 0; c < ns; c++) begin
         put(1'b1, c == 0, (c == 0) && (l == 0), pat(f, l, c), (c == 0) ? alg : alg_mid, tag);
         if (gap && (c % 3 == 1)) put(1'b0, 1'b0, 1'b0, 0, alg_mid, tag);
      end
   endtask

   initial begin
      #4ms;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0, "R1", int'(out_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid == 1'b0, "R1", int'(out_valid), 0);

      // Sweep every select code over several frames (R3..R8)
      for (int a = 0; a < 4; a++)
         for (int f = 0; f < 3; f++)
            for (int l = 0; l < 5; l++)
               line(f, l, NS, a, a, 1'b0, "");

      // Shorter lines than the maximum (R10)
      for (int l = 0; l < 4; l++) line(5, l, NS - 2, 2, 2, 1'b0, (l < 2) ? "" : "R10");

      // Select changes in mid-line are ignored (R9)
      for (int l = 0; l < 4; l++) line(7, l, NS, (l == 3) ? 3 : 1, 3, 1'b0, (l < 2) ? "" : "R9");

      // Idle gaps inside lines keep column alignment (R10)
      for (int l = 0; l < 4; l++) line(8, l, NS, 3, 0, 1'b1, (l < 2) ? "" : "R10");

      for (int i = 0; i < 4; i++) put(1'b0, 1'b0, 1'b0, 0, 0, "R2");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule